// File: doc/BRIEF.md
# Grouped Interrupt Status Resolver

This block gathers interrupt requests from three source groups (critical, main and peripheral) and from a register of sixteen DMA task interrupt lines. It combines them into one encoded status word and reduces that word to a single interrupt identifier. The identifier is eight bits wide: a two-bit group number sits above a six-bit index. Critical requests outrank main requests, and main requests outrank peripheral ones. A peripheral request can be promoted so that it shows up in the critical or main field as a marker code. The resolver sends such a marker back to the peripheral field. Peripheral code 0 stands for "some DMA task", and it is expanded further into the number of the lowest active task.

Inside the block, the DMA task pending bits are held in a register. Tasks set these bits with one-cycle pulses, and software clears them with a write-one-to-clear port. A separate mask register disables individual tasks. The resolved identifier is produced by a two-state machine:

- **ST_IDLE**: the block presents no interrupt.
- **ST_HOLD**: the block presents an identifier and keeps it until the source behind it goes away.

The transitions are:

- **T_GRANT** (ST_IDLE to ST_HOLD): taken when any field resolves.
- **T_KEEP** (ST_HOLD to ST_HOLD): taken while the held source is still live.
- **T_RELEASE** (ST_HOLD to ST_IDLE): taken when the held source clears.
- **T_WAIT** (ST_IDLE to ST_IDLE): taken when nothing is pending.

Top module: `pirq_status_resolver`

## Requirements
- R1: The identifier is `{group[1:0], index[5:0]}`. The group codes are 0 for critical, 1 for main, 2 for peripheral and 3 for DMA task.
- R2: The status word is built from three fields; all bits not listed are 0.
  - The critical field is valid when bit 10 is set, and its code is in bits 9:8.
  - The main field is valid when bit 21 is set, and its code is in bits 20:16.
  - The peripheral field is valid when bit 29 is set, and its code is in bits 28:24.
- R3: Only the highest valid field is resolved. The order from highest to lowest is critical, then main, then peripheral. A critical code other than 2 gives group 0 with that code as the index. A main code other than 4 gives group 1.
- R4: `per_boost` selects promotion (2'b00 none, 2'b01 low, 2'b1x high).
  - A high promotion of a valid peripheral field shows critical code 2 when `crit_req` is 0.
  - A low promotion shows main code 4 when `main_req` is 0.
  - Critical code 2 or main code 4 resolves from the peripheral field when that field is valid. If the peripheral field is not valid, resolution falls through to the next lower field.
- R5: The peripheral field shows code 0 whenever any task is active, where active means pending and not masked. Otherwise it shows `per_code`, and only when `per_req` is set and `per_code` is not 0. Code 0 resolves to group 3, with the index set to the lowest-numbered active task.
- R6: A `task_set` bit sets its pending bit. A write of 1 to a bit through `task_clr_bits` (with `task_clr_we`) clears that pending bit. When a set and a clear hit the same bit in the same cycle, the set wins. Changes take effect on the next clock edge.
- R7: A mask bit of 1 disables its task, and the mask resets to all ones. A masked task's pending bit is still recorded but does not count as active.
- R8: When no field resolves, `irq_valid` is 0. Whenever `irq_valid` is 0, `irq_id` is 0. Reset clears the valid flag, the identifier and all pending bits.
- R9: From ST_IDLE, the identifier and valid flag appear one clock after the status word resolves.
- R10: In ST_HOLD, `irq_id` stays constant while its source remains live. A source is live when:
  - for group 0, 1 or 2, its field is valid, holds the same code, and that code is not a marker;
  - for group 3, the task is still active.
  When the source stops being live, valid drops for one cycle and the block then resolves again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crit_req | input | 1 | Critical group request |
| crit_code | input | 2 | Critical source code |
| main_req | input | 1 | Main group request |
| main_code | input | 5 | Main source code |
| per_req | input | 1 | Peripheral group request |
| per_code | input | 5 | Peripheral source code (0 reserved for DMA tasks) |
| per_boost | input | 2 | Peripheral promotion: 00 none, 01 low, 1x high |
| task_set | input | 16 | Per-task pending set pulses |
| task_clr_we | input | 1 | Write strobe for pending clear |
| task_clr_bits | input | 16 | Write-one-to-clear pattern |
| task_mask_we | input | 1 | Write strobe for task mask |
| task_mask_bits | input | 16 | New mask (1 disables) |
| status_word | output | 32 | Encoded group status word |
| irq_valid | output | 1 | Identifier valid |
| irq_id | output | 8 | Resolved identifier |

## Verification
A corrupted pending or mask bit shows up as a wrong peripheral code in `status_word` in the same cycle that the bit is in effect. It also shows up as a wrong group-3 index one clock later. A state machine stuck in ST_HOLD would keep `irq_valid` high after its source had cleared. That error becomes visible at the first clock after the release, because the bench models both the one-cycle valid gap and the re-resolution. Random stimulus that keeps requests sparse makes promotion, priority order and hold release occur thousands of times, and each of them is compared every cycle.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int GRP_W  = 2;
    localparam int IDX_W  = 6;
    localparam int ID_W   = GRP_W + IDX_W;
    localparam int STAT_W = 32;

    localparam int CRIT_VLD_BIT = 10;
    localparam int CRIT_LSB     = 8;
    localparam int MAIN_VLD_BIT = 21;
    localparam int MAIN_LSB     = 16;
    localparam int PERI_VLD_BIT = 29;
    localparam int PERI_LSB     = 24;

    localparam logic [1:0] CRIT_MARK = 2'd2;
    localparam logic [4:0] MAIN_MARK = 5'd4;
    localparam logic [4:0] TASK_CODE = 5'd0;

    typedef enum logic [GRP_W-1:0] {
        GRP_CRIT = 2'd0,
        GRP_MAIN = 2'd1,
        GRP_PERI = 2'd2,
        GRP_TASK = 2'd3
    } grp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;

    typedef struct packed {
        logic       crit_v;
        logic [1:0] crit_c;
        logic       main_v;
        logic [4:0] main_c;
        logic       per_v;
        logic [4:0] per_c;
    } fields_t;
endpackage

// File: rtl/pirq_task_reg.sv
module pirq_task_reg #(
    parameter int NUM_TASKS = 16,
    localparam int TIDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] task_set,
    input  logic                 clr_we,
    input  logic [NUM_TASKS-1:0] clr_bits,
    input  logic                 mask_we,
    input  logic [NUM_TASKS-1:0] mask_bits,
    output logic [NUM_TASKS-1:0] active,
    output logic                 any_active,
    output logic [TIDX_W-1:0]    low_idx
);
    logic [NUM_TASKS-1:0] pend_q;
    logic [NUM_TASKS-1:0] mask_q;
    logic [NUM_TASKS-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    // pending: write-one-to-clear, set pulses take precedence
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_eff) | task_set;
        end
    end

    // mask: 1 disables, all disabled out of reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= mask_bits;
        end
    end

    assign active     = pend_q & ~mask_q;
    assign any_active = |active;

    // lowest-numbered active task
    always_comb begin
        low_idx = '0;
        for (int i = NUM_TASKS - 1; i >= 0; i--) begin
            if (active[i]) begin
                low_idx = TIDX_W'(i);
            end
        end
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((pend_q & $past(clr_bits & ~task_set)) == '0)) // R6
        else $error("pending bit survived a clear");

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (task_set != '0) |=> ((pend_q & $past(task_set)) == $past(task_set))) // R6
        else $error("set pulse lost");
endmodule

// File: rtl/pirq_field_enc.sv
module pirq_field_enc
    import pirq_pkg::*;
(
    input  logic              crit_req,
    input  logic [1:0]        crit_code,
    input  logic              main_req,
    input  logic [4:0]        main_code,
    input  logic              per_req,
    input  logic [4:0]        per_code,
    input  logic [1:0]        per_boost,
    input  logic              task_any,
    output fields_t           fld,
    output logic [STAT_W-1:0] status
);
    logic per_live;
    logic promo_hi;
    logic promo_lo;

    assign per_live = task_any | (per_req && (per_code != TASK_CODE));
    assign promo_hi = per_live && per_boost[1];
    assign promo_lo = per_live && (per_boost == 2'b01);

    always_comb begin
        fld        = '0;
        fld.per_v  = per_live;
        fld.per_c  = task_any ? TASK_CODE : per_code;
        fld.crit_v = crit_req | promo_hi;
        fld.crit_c = crit_req ? crit_code : CRIT_MARK;
        fld.main_v = main_req | promo_lo;
        fld.main_c = main_req ? main_code : MAIN_MARK;
    end

    always_comb begin
        status                            = '0;
        status[CRIT_VLD_BIT]              = fld.crit_v;
        status[CRIT_LSB +: 2]             = fld.crit_v ? fld.crit_c : 2'd0;
        status[MAIN_VLD_BIT]              = fld.main_v;
        status[MAIN_LSB +: 5]             = fld.main_v ? fld.main_c : 5'd0;
        status[PERI_VLD_BIT]              = fld.per_v;
        status[PERI_LSB +: 5]             = fld.per_v ? fld.per_c : 5'd0;
    end
endmodule

// File: rtl/pirq_resolve.sv
module pirq_resolve
    import pirq_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    localparam int TIDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  fields_t           fld,
    input  logic [TIDX_W-1:0] task_low,
    output logic              hit,
    output logic [ID_W-1:0]   id
);
    logic [ID_W-1:0] per_id;

    always_comb begin
        if (fld.per_c == TASK_CODE) begin
            per_id = {GRP_TASK, IDX_W'(task_low)};
        end else begin
            per_id = {GRP_PERI, IDX_W'(fld.per_c)};
        end
    end

    always_comb begin
        hit = 1'b1;
        id  = '0;
        if (fld.crit_v && (fld.crit_c != CRIT_MARK)) begin
            id = {GRP_CRIT, IDX_W'(fld.crit_c)};
        end else if (fld.crit_v && fld.per_v) begin
            id = per_id;
        end else if (fld.main_v && (fld.main_c != MAIN_MARK)) begin
            id = {GRP_MAIN, IDX_W'(fld.main_c)};
        end else if (fld.main_v && fld.per_v) begin
            id = per_id;
        end else if (fld.per_v) begin
            id = per_id;
        end else begin
            hit = 1'b0;
        end
    end
endmodule

// File: rtl/pirq_hold_check.sv
module pirq_hold_check
    import pirq_pkg::*;
#(
    parameter int NUM_TASKS = 16,
    localparam int TIDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  fields_t              fld,
    input  logic [NUM_TASKS-1:0] active,
    input  logic [ID_W-1:0]      held_id,
    output logic                 live
);
    grp_e             grp;
    logic [IDX_W-1:0] idx;

    assign grp = grp_e'(held_id[ID_W-1 -: GRP_W]);
    assign idx = held_id[IDX_W-1:0];

    always_comb begin
        live = 1'b0;
        unique case (grp)
            GRP_CRIT: live = fld.crit_v && (fld.crit_c != CRIT_MARK)
                             && (idx == IDX_W'(fld.crit_c));
            GRP_MAIN: live = fld.main_v && (fld.main_c != MAIN_MARK)
                             && (idx == IDX_W'(fld.main_c));
            GRP_PERI: live = fld.per_v && (fld.per_c != TASK_CODE)
                             && (idx == IDX_W'(fld.per_c));
            GRP_TASK: live = (int'(idx) < NUM_TASKS) && active[idx[TIDX_W-1:0]];
            default:  live = 1'b0;
        endcase
    end
endmodule

// File: rtl/pirq_status_resolver.sv
module pirq_status_resolver
    import pirq_pkg::*;
#(
    parameter int NUM_TASKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 crit_req,
    input  logic [1:0]           crit_code,
    input  logic                 main_req,
    input  logic [4:0]           main_code,
    input  logic                 per_req,
    input  logic [4:0]           per_code,
    input  logic [1:0]           per_boost,
    input  logic [NUM_TASKS-1:0] task_set,
    input  logic                 task_clr_we,
    input  logic [NUM_TASKS-1:0] task_clr_bits,
    input  logic                 task_mask_we,
    input  logic [NUM_TASKS-1:0] task_mask_bits,
    output logic [31:0]          status_word,
    output logic                 irq_valid,
    output logic [7:0]           irq_id
);
    localparam int TIDX_W = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1;

    logic [NUM_TASKS-1:0] active;
    logic                 any_active;
    logic [TIDX_W-1:0]    low_idx;
    fields_t              fld;
    logic                 res_hit;
    logic [ID_W-1:0]      res_id;
    logic                 live;
    state_e               state_q, state_d;
    logic [ID_W-1:0]      id_q;

    pirq_task_reg #(.NUM_TASKS(NUM_TASKS)) u_tasks (
        .clk        (clk),
        .rst_n      (rst_n),
        .task_set   (task_set),
        .clr_we     (task_clr_we),
        .clr_bits   (task_clr_bits),
        .mask_we    (task_mask_we),
        .mask_bits  (task_mask_bits),
        .active     (active),
        .any_active (any_active),
        .low_idx    (low_idx)
    );

    pirq_field_enc u_enc (
        .crit_req  (crit_req),
        .crit_code (crit_code),
        .main_req  (main_req),
        .main_code (main_code),
        .per_req   (per_req),
        .per_code  (per_code),
        .per_boost (per_boost),
        .task_any  (any_active),
        .fld       (fld),
        .status    (status_word)
    );

    pirq_resolve #(.NUM_TASKS(NUM_TASKS)) u_res (
        .fld      (fld),
        .task_low (low_idx),
        .hit      (res_hit),
        .id       (res_id)
    );

    pirq_hold_check #(.NUM_TASKS(NUM_TASKS)) u_hold (
        .fld     (fld),
        .active  (active),
        .held_id (id_q),
        .live    (live)
    );

    // next-state: T_WAIT, T_GRANT, T_KEEP, T_RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = res_hit ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = live ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered identifier
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: id_q <= res_hit ? res_id : '0;
                ST_HOLD: id_q <= live ? id_q : '0;
                default: id_q <= '0;
            endcase
        end
    end

    assign irq_valid = (state_q == ST_HOLD);
    assign irq_id    = id_q;

    AST_HOLD_ID_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && $past(irq_valid)) |-> $stable(irq_id)) // R10
        else $error("identifier moved while held");

    AST_CRIT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && status_word[10] && (status_word[9:8] != 2'd2))
        |=> (irq_valid && (irq_id[7:6] == 2'd0))) // R3
        else $error("critical field not resolved first");

    AST_NO_REQ_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !status_word[10] && !status_word[21] && !status_word[29])
        |=> (!irq_valid && (irq_id == 8'd0))) // R8
        else $error("valid raised with empty status");

    AST_TASK_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (active != '0) |-> (status_word[29] && (status_word[28:24] == 5'd0))) // R5
        else $error("active task not shown as peripheral code 0");
endmodule

// File: tb/test_pirq_status_resolver.sv
`timescale 1ns/1ps
module test_pirq_status_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        crit_req = 1'b0;
    logic [1:0]  crit_code = '0;
    logic        main_req = 1'b0;
    logic [4:0]  main_code = '0;
    logic        per_req = 1'b0;
    logic [4:0]  per_code = '0;
    logic [1:0]  per_boost = '0;
    logic [15:0] task_set = '0;
    logic        task_clr_we = 1'b0;
    logic [15:0] task_clr_bits = '0;
    logic        task_mask_we = 1'b0;
    logic [15:0] task_mask_bits = '0;
    logic [31:0] status_word;
    logic        irq_valid;
    logic [7:0]  irq_id;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    logic [15:0] m_pend;
    logic [15:0] m_mask;
    logic        m_valid;
    logic [7:0]  m_id;

    always #2 clk = ~clk;

    pirq_status_resolver i_pirq_status_resolver (
        .clk(clk), .rst_n(rst_n),
        .crit_req(crit_req), .crit_code(crit_code),
        .main_req(main_req), .main_code(main_code),
        .per_req(per_req), .per_code(per_code), .per_boost(per_boost),
        .task_set(task_set), .task_clr_we(task_clr_we), .task_clr_bits(task_clr_bits),
        .task_mask_we(task_mask_we), .task_mask_bits(task_mask_bits),
        .status_word(status_word), .irq_valid(irq_valid), .irq_id(irq_id)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R2, R4, R5: expected status word from inputs and model registers
    function automatic logic [31:0] exp_status();
        logic [31:0] s = '0;
        logic [15:0] act = m_pend & ~m_mask;
        logic pv = (act != 0) || (per_req && per_code != 0);
        logic [4:0] pc = (act != 0) ? 5'd0 : per_code;
        logic cv = crit_req || (pv && per_boost[1]);
        logic mv = main_req || (pv && per_boost == 2'b01);
        if (cv) begin s[10] = 1'b1; s[9:8] = crit_req ? crit_code : 2'd2; end
        if (mv) begin s[21] = 1'b1; s[20:16] = main_req ? main_code : 5'd4; end
        if (pv) begin s[29] = 1'b1; s[28:24] = pc; end
        return s;
    endfunction

    function automatic int low_task(input logic [15:0] a);
        for (int i = 0; i < 16; i++) if (a[i]) return i;
        return 0;
    endfunction

    // R1, R3, R4, R5: expected resolution; bit 8 is hit
    function automatic logic [8:0] exp_resolve(input logic [31:0] s);
        logic [7:0] pid;
        pid = (s[28:24] == 0) ? {2'd3, 6'(low_task(m_pend & ~m_mask))}
                              : {2'd2, 1'b0, s[28:24]};
        if (s[10] && s[9:8] != 2)   return {1'b1, 2'd0, 4'd0, s[9:8]};
        if (s[10] && s[29])         return {1'b1, pid};
        if (s[21] && s[20:16] != 4) return {1'b1, 2'd1, 1'b0, s[20:16]};
        if (s[21] && s[29])         return {1'b1, pid};
        if (s[29])                  return {1'b1, pid};
        return 9'd0;
    endfunction

    // R10: held source still live
    function automatic bit exp_live(input logic [31:0] s, input logic [7:0] id);
        case (id[7:6])
            2'd0: return s[10] && s[9:8] != 2 && id[5:0] == {4'd0, s[9:8]};
            2'd1: return s[21] && s[20:16] != 4 && id[5:0] == {1'b0, s[20:16]};
            2'd2: return s[29] && s[28:24] != 0 && id[5:0] == {1'b0, s[28:24]};
            default: return id[5:4] == 0 && (m_pend[id[3:0]] && !m_mask[id[3:0]]);
        endcase
    endfunction

    // Advance model by one edge using inputs held since last negedge, then compare.
    task automatic tick(input string tag);
        logic [31:0] s;
        logic [8:0] r;
        s = exp_status();
        r = exp_resolve(s);
        @(negedge clk);
        if (!m_valid) begin                       // R9: one-cycle latency
            m_valid = r[8];
            m_id    = r[8] ? r[7:0] : 8'd0;
        end else if (!exp_live(s, m_id)) begin    // R10: release
            m_valid = 1'b0;
            m_id    = 8'd0;
        end
        m_pend = (m_pend & ~(task_clr_we ? task_clr_bits : 16'd0)) | task_set;  // R6
        if (task_mask_we) m_mask = task_mask_bits;                              // R7
        check({tag, " valid"}, 32'(irq_valid), 32'(m_valid));
        check({tag, " id"}, 32'(irq_id), 32'(m_id));
    endtask

    task automatic drive_quiet();
        crit_req = 0; main_req = 0; per_req = 0; per_boost = 0;
        task_set = 0; task_clr_we = 0; task_clr_bits = 0; task_mask_we = 0;
    endtask

    task automatic comb_check(input string tag);
        #1;
        check({tag, " status"}, status_word, exp_status());
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        m_pend = 0; m_mask = 16'hffff; m_valid = 0; m_id = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        check("R8 reset valid", 32'(irq_valid), 32'd0);
        check("R8 reset id", 32'(irq_id), 32'd0);
        check("R8 reset status", status_word, 32'd0);
        rst_n = 1'b1;

        // R7: masked tasks stay inactive
        task_set = 16'h0220; comb_check("R7 masked"); tick("R7 masked");
        drive_quiet(); comb_check("R7 masked idle"); tick("R7 masked idle");
        check("R7 no valid", 32'(irq_valid), 32'd0);
        // R5: unmask, lowest task 5 wins
        task_mask_we = 1; task_mask_bits = 16'h0000; comb_check("R5 unmask"); tick("R5 unmask");
        drive_quiet(); comb_check("R5 task"); tick("R5 task");
        tick("R5 grant");
        check("R5 task id", 32'(irq_id), 32'h0C5);
        // R6: clear 5 and re-set 9 same cycle (set wins)
        task_clr_we = 1; task_clr_bits = 16'h0220; task_set = 16'h0200;
        comb_check("R6 clr"); tick("R6 clr");
        drive_quiet(); comb_check("R6 release"); tick("R6 release");
        tick("R6 regrant");
        check("R6 task9", 32'(irq_id), 32'h0C9);
        task_clr_we = 1; task_clr_bits = 16'hffff; tick("R6 clear all");
        drive_quiet(); repeat (3) tick("R8 drain");

        // R4: high promotion of peripheral code 7
        per_req = 1; per_code = 5'd7; per_boost = 2'b10; comb_check("R4 high"); tick("R4 high");
        tick("R4 hold"); check("R4 promo id", 32'(irq_id), 32'h087);
        // R4: low promotion + main marker while critical idle
        per_boost = 2'b01; comb_check("R4 low"); tick("R4 low");
        // R3: critical over main
        drive_quiet(); repeat (2) tick("R3 drain");
        crit_req = 1; crit_code = 2'd1; main_req = 1; main_code = 5'd3;
        comb_check("R3 prio"); tick("R3 prio"); tick("R3 hold");
        check("R3 crit id", 32'(irq_id), 32'h001);
        // R10: swap critical code -> release gap then new id
        crit_code = 2'd3; comb_check("R10 swap"); tick("R10 swap");
        check("R10 gap", 32'(irq_valid), 32'd0);
        tick("R10 regrant"); check("R1 id form", 32'(irq_id), 32'h003);
        drive_quiet(); repeat (2) tick("R8 idle");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            crit_req  = ($urandom % 10) == 0;
            crit_code = 2'($urandom);
            main_req  = ($urandom % 7) == 0;
            main_code = 5'($urandom);
            per_req   = ($urandom % 4) == 0;
            per_code  = 5'($urandom);
            per_boost = 2'($urandom);
            task_set  = 16'($urandom & $urandom & $urandom & $urandom);
            task_clr_we   = ($urandom % 4) == 0;
            task_clr_bits = 16'($urandom);
            task_mask_we  = ($urandom % 20) == 0;
            task_mask_bits = 16'($urandom & $urandom);
            comb_check("R2 random");
            tick("R3 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule